// File: doc/BRIEF.md
# Shared Reset/Track Pulse Width Discriminator

This block watches one active-low control input that carries two meanings, chosen by how long the input stays low. The input is brought into the clock domain through a chain of flip-flops. A saturating counter then measures each low interval in clock cycles. When the interval ends, or when it runs past its upper bound, the block classifies it.

There are three classes:
- **Short interval:** treated as noise. It produces only a one-cycle `glitch_pulse` that can be observed.
- **Interval within the reset window:** produces a one-cycle `reset_pulse`, which the rest of the device uses to return to its power-on state. This strobe is issued only after the input has risen. Before that point, nobody can know that the interval would not grow too long.
- **Interval beyond the window:** not a reset at all. As soon as the count passes the upper bound, `hold_level` rises. It stays high until the input goes high again. While it is high, downstream acquisition is held off.

The block carries no data stream, so there is no valid/ready handshake. Every pin is a plain control or status level, or a one-cycle strobe that needs no back-pressure. Both window limits are parameters given in clock cycles. The defaults, 9 and 20, match roughly 90 ns and 200 ns at a 100 MHz clock.

Top module: `trp_discriminator`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released with `req_n` high, `reset_pulse`, `glitch_pulse` and `hold_level` are all 0.
- R2: `req_n` passes through `SYNC_STAGES` (default 2) flip-flops. The interval width is the number of rising clock edges at which the synchronized level is low. A strobe for an interval is high in the cycle after the third rising edge that follows the rise of `req_n`.
- R3: An interval of fewer than `MIN_LOW` cycles gives exactly one cycle of `glitch_pulse` and no `reset_pulse`. `glitch_pulse` and `reset_pulse` are never high together.
- R4: An interval of `MIN_LOW` to `MAX_LOW` cycles, both bounds included, gives exactly one cycle of `reset_pulse` and no `glitch_pulse`.
- R5: An interval longer than `MAX_LOW` cycles gives neither `reset_pulse` nor `glitch_pulse` when it ends.
- R6: `hold_level` rises once `MAX_LOW`+1 low samples have been counted, which is on the (`MAX_LOW`+3)-th rising edge after `req_n` falls. It stays high while the input is low and falls on the third rising edge after `req_n` rises.
- R7: The width counter saturates at `MAX_LOW`+1. A low interval of any length keeps `hold_level` high without wrapping, and it yields no strobe when it ends.
- R8: Consecutive intervals separated by a few high cycles are each classified on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the discriminator itself |
| req_n | input | 1 | Asynchronous active-low shared reset/track request |
| reset_pulse | output | 1 | One-cycle strobe for an interval inside the reset window |
| glitch_pulse | output | 1 | One-cycle strobe for an interval shorter than the window |
| hold_level | output | 1 | High while an over-long interval is in progress |

## Verification
The assertions take for granted the following about `rst_n` and `req_n`:
- `rst_n` is held low for at least one clock edge, with `req_n` idle high.
- `req_n` stays at a level for whole clock periods, so the synchronizer never sees a metastable value. The default chain width is only a model of that settling.

The stimulus keeps within these assumptions:
- It changes `req_n` only on falling clock edges.
- It holds every level for an integer number of cycles.
- It leaves several high cycles between intervals, so each strobe has cleared before the next interval begins.

// File: rtl/trp_pkg.sv
package trp_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_GLITCH = 2'd1,
    CLS_RESET  = 2'd2,
    CLS_HOLD   = 2'd3
  } pulse_cls_e;

  function automatic int cnt_width(input int max_low);
    return $clog2(max_low + 2);
  endfunction

endpackage

// File: rtl/trp_sync.sv
module trp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/trp_width_cnt.sv
module trp_width_cnt #(
  parameter int MAX_LOW = 20,
  localparam int CW     = trp_pkg::cnt_width(MAX_LOW),
  localparam int SAT    = MAX_LOW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  output logic [CW-1:0] cnt,
  output logic          ended
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (lvl)        cnt <= '0;
    else if (cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  // first high sample after at least one low sample
  assign ended = lvl && (cnt != '0);

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT_V && !lvl) |=> (cnt == SAT_V)); // R7
endmodule

// File: rtl/trp_classify.sv
module trp_classify #(
  parameter int MIN_LOW = 9,
  parameter int MAX_LOW = 20,
  localparam int CW     = trp_pkg::cnt_width(MAX_LOW),
  localparam int SAT    = MAX_LOW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic [CW-1:0] cnt,
  input  logic          ended,
  output logic          reset_pulse,
  output logic          glitch_pulse,
  output logic          hold_level
);
  import trp_pkg::*;

  localparam logic [CW-1:0] MIN_V = CW'(MIN_LOW);
  localparam logic [CW-1:0] MAX_V = CW'(MAX_LOW);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  pulse_cls_e cls;

  always_comb begin
    cls = CLS_NONE;
    if (ended) begin
      if (cnt < MIN_V)       cls = CLS_GLITCH;
      else if (cnt <= MAX_V) cls = CLS_RESET;
      else                   cls = CLS_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_pulse  <= 1'b0;
      glitch_pulse <= 1'b0;
    end else begin
      reset_pulse  <= (cls == CLS_RESET);
      glitch_pulse <= (cls == CLS_GLITCH);
    end
  end

  assign hold_level = (cnt == SAT_V);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse); // R4
  AST_GLITCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_pulse |=> !glitch_pulse); // R3
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_pulse && glitch_pulse)); // R3
  AST_NO_RST_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> !$past(hold_level)); // R5
  AST_HOLD_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_level |-> !$past(lvl)); // R6
endmodule

// File: rtl/trp_discriminator.sv
module trp_discriminator #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 9,
  parameter int MAX_LOW     = 20,
  localparam int CW         = trp_pkg::cnt_width(MAX_LOW)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic reset_pulse,
  output logic glitch_pulse,
  output logic hold_level
);
  logic          lvl;
  logic [CW-1:0] cnt;
  logic          ended;

  trp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (req_n),
    .sync_out (lvl)
  );

  trp_width_cnt #(.MAX_LOW(MAX_LOW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .cnt   (cnt),
    .ended (ended)
  );

  trp_classify #(.MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)) u_cls (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl          (lvl),
    .cnt          (cnt),
    .ended        (ended),
    .reset_pulse  (reset_pulse),
    .glitch_pulse (glitch_pulse),
    .hold_level   (hold_level)
  );

  AST_HOLD_BLOCKS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_level |-> !(reset_pulse || glitch_pulse)); // R5
endmodule

// File: tb/tb_trp_discriminator.sv
`timescale 1ns/1ps
module tb_trp_discriminator;
  localparam int MIN_LOW = 9;
  localparam int MAX_LOW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic reset_pulse, glitch_pulse, hold_level;

  int checks = 0;
  int fails  = 0;
  int n_rst  = 0;
  int n_gl   = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  trp_discriminator #(.SYNC_STAGES(2), .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .reset_pulse(reset_pulse), .glitch_pulse(glitch_pulse), .hold_level(hold_level)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (reset_pulse)  n_rst++;
      if (glitch_pulse) n_gl++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a low interval of n cycles, then idle high long enough for the strobe to clear.
  task automatic pulse(input int n);
    @(negedge clk) req_n = 1'b0;
    repeat (n) @(negedge clk);
    req_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check({reset_pulse, glitch_pulse, hold_level} == 3'b000, "R1 during reset",
          {reset_pulse, glitch_pulse, hold_level}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({reset_pulse, glitch_pulse, hold_level} == 3'b000, "R1 after release",
          {reset_pulse, glitch_pulse, hold_level}, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_class(input int n, input int exp_r, input int exp_g, input string tag);
    int r0 = n_rst;
    int g0 = n_gl;
    pulse(n);
    check(n_rst - r0 == exp_r, {tag, " reset strobes"}, n_rst - r0, exp_r);
    check(n_gl - g0 == exp_g, {tag, " glitch strobes"}, n_gl - g0, exp_g);
  endtask

  task automatic t_latency();
    @(negedge clk) req_n = 1'b0;
    repeat (MIN_LOW + 2) @(negedge clk);
    req_n = 1'b1;
    @(negedge clk);
    check(reset_pulse == 1'b0, "R2 strobe early edge 1", reset_pulse, 0);
    @(negedge clk);
    check(reset_pulse == 1'b0, "R2 strobe early edge 2", reset_pulse, 0);
    @(negedge clk);
    check(reset_pulse == 1'b1, "R2 strobe at third edge", reset_pulse, 1);
    @(negedge clk);
    check(reset_pulse == 1'b0, "R4 strobe one cycle", reset_pulse, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_hold();
    int r0 = n_rst;
    int g0 = n_gl;
    @(negedge clk) req_n = 1'b0;
    repeat (MAX_LOW + 2) @(negedge clk);
    check(hold_level == 1'b0, "R6 hold not before limit", hold_level, 0);
    @(negedge clk);
    check(hold_level == 1'b1, "R6 hold at limit", hold_level, 1);
    repeat (10) @(negedge clk);
    check(hold_level == 1'b1, "R6 hold stays while low", hold_level, 1);
    req_n = 1'b1;
    repeat (2) @(negedge clk);
    check(hold_level == 1'b1, "R6 hold before release edge", hold_level, 1);
    @(negedge clk);
    check(hold_level == 1'b0, "R6 hold drops on third edge", hold_level, 0);
    repeat (5) @(negedge clk);
    check(n_rst == r0 && n_gl == g0, "R5 no strobe after long", n_rst - r0 + n_gl - g0, 0);
  endtask

  task automatic t_saturate();
    int r0 = n_rst;
    int g0 = n_gl;
    @(negedge clk) req_n = 1'b0;
    repeat (300) @(negedge clk);
    check(hold_level == 1'b1, "R7 hold after 300 cycles", hold_level, 1);
    req_n = 1'b1;
    repeat (6) @(negedge clk);
    check(n_rst == r0 && n_gl == g0, "R7 no strobe after saturation",
          n_rst - r0 + n_gl - g0, 0);
    check(hold_level == 1'b0, "R7 hold cleared", hold_level, 0);
  endtask

  task automatic t_back_to_back();
    int r0 = n_rst;
    int g0 = n_gl;
    @(negedge clk) req_n = 1'b0;
    repeat (12) @(negedge clk);
    req_n = 1'b1;
    repeat (3) @(negedge clk);
    req_n = 1'b0;
    repeat (4) @(negedge clk);
    req_n = 1'b1;
    repeat (3) @(negedge clk);
    req_n = 1'b0;
    repeat (15) @(negedge clk);
    req_n = 1'b1;
    repeat (6) @(negedge clk);
    check(n_rst - r0 == 2, "R8 reset strobes in burst", n_rst - r0, 2);
    check(n_gl - g0 == 1, "R8 glitch strobes in burst", n_gl - g0, 1);
  endtask

  initial begin
    repeat (50000) @(negedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_class(1, 0, 1, "R3 width 1");
    t_class(MIN_LOW - 1, 0, 1, "R3 width min-1");
    t_class(MIN_LOW, 1, 0, "R4 width min");
    t_class(14, 1, 0, "R4 width mid");
    t_class(MAX_LOW, 1, 0, "R4 width max");
    t_class(MAX_LOW + 1, 0, 0, "R5 width max+1");
    t_latency();
    t_hold();
    t_saturate();
    t_back_to_back();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule